// File: doc/BRIEF.md
# Run-time Truncatable Signed Multiply-Accumulate

This block multiplies two signed two's complement operands of N bits each. It adds each product into a wider running accumulator. The partial-product matrix follows the Baugh-Wooley form: in every term that involves exactly one operand sign bit, the bit is inverted. Two fixed correction bits are added at weights 2^N and 2^(2N-1). The matrix is reduced by a chain of carry-save adders and then by one carry-propagate adder.

A truncation value T arrives with each operation. Every matrix column of weight 2^j with j < T is forced to zero, and that includes the correction bits. The columns that are switched off therefore hold still, and only the upper part of the product is computed. T may change from one operation to the next. With T = 0 the product is the exact signed product.

The product is registered one cycle after the input strobe. One cycle later, the registered product is either added to the accumulator or loaded into it. The accumulator is sign extended to 2N+G bits and wraps on overflow.

Top module: `ptm_mac`

## Requirements
- R1: With T = 0 the registered product equals the exact signed product a·b, taken modulo 2^(2N).
- R2: Column j is enabled only when j ≥ T. The product equals, modulo 2^(2N), the sum over enabled columns of the Baugh-Wooley bits. Those are the terms a_i·b_k at weight 2^(i+k), inverted when exactly one of i and k is N-1, plus the correction bits at columns N and 2N-1.
- R3: Product bits below position T are always zero.
- R4: The exact product minus the truncated product equals, modulo 2^(2N), the weighted sum of the removed bits, which is never negative.
- R5: T is taken per operation. Operations issued on back-to-back cycles with different T values each use their own T.
- R6: `prod_valid` rises exactly one cycle after `in_valid`, and `prod` holds that operation's result.
- R7: One cycle after `prod_valid`, `acc_valid` is set. If `in_clear` was 0 for that operation, `acc` becomes the old `acc` plus the sign-extended product.
- R8: An operation issued with `in_clear` = 1 loads the sign-extended product into `acc` in place of adding it.
- R9: The accumulator is 2N+G bits wide and wraps modulo 2^(2N+G) without saturation.
- R10: While `rst` is high, `prod`, `acc`, `prod_valid` and `acc_valid` all become zero.
- R11: A cycle with no product valid leaves `acc` unchanged and clears `acc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_clear | input | 1 | Load the accumulator with this product instead of adding it |
| op_a | input | N | Signed multiplicand |
| op_b | input | N | Signed multiplier |
| trunc_sel | input | clog2(2N) | Number of low columns to disable (T) |
| prod_valid | output | 1 | Product register holds a new result |
| prod | output | 2N | Registered truncated product |
| acc_valid | output | 1 | Accumulator updated this cycle |
| acc | output | 2N+G | Accumulator value |

## Verification
The assertions check the following on every cycle: the one-cycle valid delays, the zero bits below T in each product, exactness of the product when T is zero, and the add, load and hold behaviour of the accumulator. The match between each truncated product and the column sum of enabled bits, and the non-negative error identity, can only be shown by the bench. The bench sweeps every T against a broad operand grid and also runs a stream in which T changes every cycle. Accumulator wrap past 2^(2N+G-1) is shown by one long scenario with a known final value.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    localparam int DEF_N = 8;
    localparam int DEF_G = 8;

    typedef enum logic {
        ACC_ADD  = 1'b0,
        ACC_LOAD = 1'b1
    } acc_op_e;

    // A matrix term is inverted when exactly one factor is an operand sign bit.
    function automatic logic bw_inverted(input int row, input int col_idx, input int n);
        return logic'((row == n - 1) != (col_idx == n - 1));
    endfunction

    // Columns that carry a fixed correction one.
    function automatic logic bw_fixed_one(input int col, input int n);
        return logic'((col == n) || (col == 2 * n - 1));
    endfunction

endpackage

// File: rtl/ptm_ppgen.sv
module ptm_ppgen
    import ptm_pkg::*;
#(
    parameter int N  = DEF_N,
    parameter int TW = $clog2(2 * N),
    localparam int PW = 2 * N
) (
    input  logic [N-1:0]         op_a,
    input  logic [N-1:0]         op_b,
    input  logic [TW-1:0]        trunc_sel,
    output logic [N:0][PW-1:0]   rows
);

    logic [PW-1:0] col_en;

    genvar gc;
    generate
        for (gc = 0; gc < PW; gc++) begin : g_col
            assign col_en[gc] = (TW'(gc) >= trunc_sel);
        end
    endgenerate

    always_comb begin
        rows = '0;
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < N; k++) begin
                rows[i][i + k] = ((op_a[i] & op_b[k]) ^ bw_inverted(i, k, N)) & col_en[i + k];
            end
        end
        for (int c = 0; c < PW; c++) begin
            rows[N][c] = bw_fixed_one(c, N) & col_en[c];
        end
    end

endmodule

// File: rtl/ptm_csa_tree.sv
module ptm_csa_tree #(
    parameter int W    = 16,
    parameter int ROWS = 9
) (
    input  logic [ROWS-1:0][W-1:0] rows,
    output logic [W-1:0]           sum
);

    logic [ROWS-2:0][W-1:0] s_v;
    logic [ROWS-2:0][W-1:0] c_v;

    assign s_v[0] = rows[0];
    assign c_v[0] = rows[1];

    genvar gk;
    generate
        for (gk = 2; gk < ROWS; gk++) begin : g_csa
            assign s_v[gk-1] = s_v[gk-2] ^ c_v[gk-2] ^ rows[gk];
            assign c_v[gk-1] = ((s_v[gk-2] & c_v[gk-2]) |
                                (s_v[gk-2] & rows[gk]) |
                                (c_v[gk-2] & rows[gk])) << 1;
        end
    endgenerate

    assign sum = s_v[ROWS-2] + c_v[ROWS-2];

endmodule

// File: rtl/ptm_acc.sv
module ptm_acc
    import ptm_pkg::*;
#(
    parameter int PW = 16,
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prod_vld,
    input  acc_op_e       op,
    input  logic [PW-1:0] prod,
    output logic [AW-1:0] acc,
    output logic          acc_vld
);

    localparam int EXT = AW - PW;

    logic [AW-1:0] prod_ext;
    assign prod_ext = {{EXT{prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            acc_vld <= 1'b0;
        end else begin
            acc_vld <= prod_vld;
            if (prod_vld) begin
                case (op)
                    ACC_LOAD: acc <= prod_ext;
                    default:  acc <= acc + prod_ext;
                endcase
            end
        end
    end

endmodule

// File: rtl/ptm_mac.sv
module ptm_mac
    import ptm_pkg::*;
#(
    parameter int N = DEF_N,
    parameter int G = DEF_G,
    localparam int PW = 2 * N,
    localparam int AW = PW + G,
    localparam int TW = $clog2(PW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_clear,
    input  logic [N-1:0]  op_a,
    input  logic [N-1:0]  op_b,
    input  logic [TW-1:0] trunc_sel,
    output logic          prod_valid,
    output logic [PW-1:0] prod,
    output logic          acc_valid,
    output logic [AW-1:0] acc
);

    typedef struct packed {
        logic          vld;
        acc_op_e       op;
        logic [PW-1:0] p;
    } prod_stage_t;

    logic [N:0][PW-1:0] pp_rows;
    logic [PW-1:0]      pp_sum;
    prod_stage_t        stage_q;

    ptm_ppgen #(.N(N), .TW(TW)) u_ppgen (
        .op_a      (op_a),
        .op_b      (op_b),
        .trunc_sel (trunc_sel),
        .rows      (pp_rows)
    );

    ptm_csa_tree #(.W(PW), .ROWS(N + 1)) u_tree (
        .rows (pp_rows),
        .sum  (pp_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.vld <= in_valid;
            if (in_valid) begin
                stage_q.op <= in_clear ? ACC_LOAD : ACC_ADD;
                stage_q.p  <= pp_sum;
            end
        end
    end

    ptm_acc #(.PW(PW), .AW(AW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .prod_vld (stage_q.vld),
        .op       (stage_q.op),
        .prod     (stage_q.p),
        .acc      (acc),
        .acc_vld  (acc_valid)
    );

    assign prod_valid = stage_q.vld;
    assign prod       = stage_q.p;

endmodule

// File: rtl/ptm_mac_chk.sv
module ptm_mac_chk #(
    parameter int N = 8,
    parameter int G = 8,
    localparam int PW = 2 * N,
    localparam int AW = PW + G,
    localparam int TW = $clog2(PW)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_clear,
    input logic [N-1:0]  op_a,
    input logic [N-1:0]  op_b,
    input logic [TW-1:0] trunc_sel,
    input logic          prod_valid,
    input logic [PW-1:0] prod,
    input logic          acc_valid,
    input logic [AW-1:0] acc
);

    localparam logic [PW-1:0] ONES = '1;

    logic [AW-1:0] prod_ext;
    assign prod_ext = {{G{prod[PW-1]}}, prod};

    // R10: reset clears both valid flags and the data outputs
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!prod_valid && !acc_valid && prod == '0 && acc == '0));

    // R6: product valid follows the strobe by one cycle
    a_r6_valid_on: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> prod_valid);
    a_r6_valid_off: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !prod_valid);

    // R3: no product bit below the truncation point
    a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((prod & ~(ONES << $past(trunc_sel))) == '0));

    // R1: exact signed product when nothing is truncated
    a_r1_exact: assert property (@(posedge clk) disable iff (rst)
        (in_valid && trunc_sel == '0) |=>
            (prod == PW'($signed($past(op_a)) * $signed($past(op_b)))));

    // R7: accumulate adds the sign-extended product
    a_r7_add: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && !$past(in_clear)) |=> (acc_valid && acc == $past(acc) + $past(prod_ext)));

    // R8: clear loads the product
    a_r8_load: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && $past(in_clear)) |=> (acc_valid && acc == $past(prod_ext)));

    // R11: idle cycle holds the accumulator
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !prod_valid |=> (!acc_valid && $stable(acc)));

endmodule

bind ptm_mac ptm_mac_chk #(.N(N), .G(G)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_clear   (in_clear),
    .op_a       (op_a),
    .op_b       (op_b),
    .trunc_sel  (trunc_sel),
    .prod_valid (prod_valid),
    .prod       (prod),
    .acc_valid  (acc_valid),
    .acc        (acc)
);

// File: tb/sim_ptm_mac.sv
module sim_ptm_mac;

    localparam int  N         = 8;
    localparam int  G         = 8;
    localparam int  PW        = 2 * N;
    localparam int  AW        = PW + G;
    localparam int  TW        = $clog2(PW);
    localparam time CLK_PER   = 10ns;
    localparam int  WATCHDOG  = 190000;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_clear;
    logic [N-1:0]  op_a;
    logic [N-1:0]  op_b;
    logic [TW-1:0] trunc_sel;
    logic          prod_valid;
    logic [PW-1:0] prod;
    logic          acc_valid;
    logic [AW-1:0] acc;

    int checks = 0;
    int errors = 0;

    // bench-side pipeline model
    logic          v1 = 1'b0;
    logic          c1 = 1'b0;
    logic [PW-1:0] e1 = '0;
    logic [PW-1:0] x1 = '0;
    logic [PW-1:0] r1 = '0;
    logic [TW-1:0] t1 = '0;
    logic          va = 1'b0;
    logic          ca = 1'b0;
    logic [AW-1:0] eacc = '0;

    always #(CLK_PER / 2) clk = ~clk;

    ptm_mac #(.N(N), .G(G)) u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_clear   (in_clear),
        .op_a       (op_a),
        .op_b       (op_b),
        .trunc_sel  (trunc_sel),
        .prod_valid (prod_valid),
        .prod       (prod),
        .acc_valid  (acc_valid),
        .acc        (acc)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // weighted sum of the matrix bits (plus correction ones) in columns lo..hi
    function automatic longint col_sum(input logic [N-1:0] a, input logic [N-1:0] b,
                                       input int lo, input int hi);
        longint s = 0;
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < N; k++) begin
                logic bit_v = a[i] & b[k];
                if ((i == N - 1) != (k == N - 1)) bit_v = ~bit_v;
                if (i + k >= lo && i + k <= hi && bit_v) s += longint'(1) << (i + k);
            end
        end
        if (N >= lo && N <= hi) s += longint'(1) << N;
        if (PW - 1 >= lo && PW - 1 <= hi) s += longint'(1) << (PW - 1);
        return s;
    endfunction

    task automatic step(input logic v, input logic c, input logic [N-1:0] a,
                        input logic [N-1:0] b, input logic [TW-1:0] t);
        longint        exact;
        logic [PW-1:0] diff;
        @(negedge clk);
        check(prod_valid == v1, "R6 prod_valid", longint'(prod_valid), longint'(v1));
        if (v1) begin
            check(prod == e1, "R2/R5 masked product", longint'(prod), longint'(e1));
            if (t1 == '0) check(prod == x1, "R1 exact product", longint'(prod), longint'(x1));
            check((prod & ~({PW{1'b1}} << t1)) == '0, "R3 low bits zero",
                  longint'(prod), longint'(prod & ({PW{1'b1}} << t1)));
            diff = x1 - prod;
            check(diff == r1, "R4 truncation error", longint'(diff), longint'(r1));
        end
        check(acc_valid == va, "R7 acc_valid", longint'(acc_valid), longint'(va));
        check(acc == eacc, !va ? "R11 acc hold" : (ca ? "R8 acc load" : "R7 acc add"),
              longint'(acc), longint'(eacc));
        // advance model
        va = v1;
        ca = c1;
        if (v1) eacc = c1 ? {{G{e1[PW-1]}}, e1} : eacc + {{G{e1[PW-1]}}, e1};
        v1 = v;
        c1 = c;
        t1 = t;
        if (v) begin
            exact = longint'($signed(a)) * longint'($signed(b));
            x1 = PW'(exact);
            e1 = PW'(col_sum(a, b, int'(t), PW - 1));
            r1 = PW'(col_sum(a, b, 0, int'(t) - 1));
        end
        in_valid  = v;
        in_clear  = c;
        op_a      = a;
        op_b      = b;
        trunc_sel = t;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
        finish_run();
    end

    initial begin
        logic [N-1:0] bv;
        rst = 1'b1; in_valid = 1'b0; in_clear = 1'b0;
        op_a = '0; op_b = '0; trunc_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(!prod_valid && !acc_valid, "R10 reset valids", longint'({prod_valid, acc_valid}), 0);
        check(prod == '0 && acc == '0, "R10 reset data", longint'(acc) + longint'(prod), 0);
        rst = 1'b0;

        // R2, R4: every T value, broad operand grid, clear on first of each block
        for (int t = 0; t < PW; t++) begin
            for (int bi = 0; bi < 32; bi++) begin
                case (bi)
                    0: bv = 8'h00;
                    1: bv = 8'h01;
                    2: bv = 8'hFF;
                    3: bv = 8'h7F;
                    4: bv = 8'h80;
                    default: bv = N'(bi * 8 + 3);
                endcase
                for (int ai = 0; ai < 256; ai++) begin
                    step(1'b1, (ai == 0 && bi == 0), N'(ai), bv, TW'(t));
                end
            end
            step(1'b0, 1'b0, '0, '0, '0); // R11 idle gap
            step(1'b0, 1'b0, '0, '0, '0);
        end

        // R5: T changes on every back-to-back operation
        for (int k = 0; k < 2000; k++) begin
            step(1'b1, (k == 0), N'(k * 37 + 11), N'(k * 53 + 5), TW'(k % PW));
        end

        // R9: accumulator wraps past its signed range
        for (int k = 0; k < 600; k++) begin
            step(1'b1, (k == 0), 8'h80, 8'h80, '0);
        end
        step(1'b0, 1'b0, '0, '0, '0);
        step(1'b0, 1'b0, '0, '0, '0);
        step(1'b0, 1'b0, '0, '0, '0);
        check(acc == AW'(600 * 16384), "R9 wrap value", longint'(acc), longint'(AW'(600 * 16384)));
        check(acc[AW-1] == 1'b1, "R9 wrapped sign", longint'(acc[AW-1]), 1);

        finish_run();
    end

endmodule